// File: doc/BRIEF.md
# Character and Bitmap Pixel Serializer

This block converts the pattern data of one 8-pixel screen cell into a stream of 4-bit colour codes, one per pixel clock. A free-running 3-bit phase counter splits time into cells of eight pixels. In the last phase of each cell the pattern byte for the next cell is captured into a shift register. Over the following eight clocks that register is emptied most significant bit first.

Each cell is drawn in one of two ways. In hi-res rendering every pattern bit is one pixel: a 1 takes the foreground colour held in the cell word, and a 0 takes the background colour. In multicolor rendering each pair of bits gives one double-width pixel, and its colour comes from one of two palettes. One palette serves text mode and uses the shared background registers. The other serves bitmap mode and uses the nibbles of the cell word.

In text mode with multicolor enabled, bit 11 of the cell word (the top bit of the colour-RAM nibble) picks the rendering for each cell separately. A 1 gives multicolor and a 0 gives hi-res. Fetching memory, drawing the border and drawing sprites are handled elsewhere. The surrounding logic must hold the cell word, the colours and the mode bits steady for the eight phases of the cell they describe.

Top module: `cell_pixel_serializer`

## Requirements
- R1: While reset is asserted and on the first clock after it, `cell_phase` is 0 and `pix_col` equals `bg_col`, because the shift register is cleared.
- R2: `cell_phase` counts up by one on every clock and wraps from 7 to 0.
- R3: On the clock edge where `cell_phase` is 7, `pat_byte` is loaded into the shift register. Pixel 0 of that pattern appears while `cell_phase` is 0.
- R4: In hi-res rendering, pixel k (k = `cell_phase`) uses pattern bit 7-k. A 1 shows `cell_word[11:8]` and a 0 shows `bg_col`.
- R5: In multicolor rendering, pixel pair j uses pattern bits [7-2j:6-2j]. Each pair is held for two pixels (phases 2j and 2j+1), and the shift register moves two places only after odd phases.
- R6: In multicolor text mode (`bitmap_mode`=0), the pair codes map as follows: 00 gives `bg_col`, 01 gives `xbg1_col`, 10 gives `xbg2_col`, and 11 gives the colour-RAM nibble.
- R7: In multicolor bitmap mode (`bitmap_mode`=1), the pair codes map as follows: 00 gives `bg_col`, 01 gives `cell_word[7:4]`, 10 gives `cell_word[3:0]`, and 11 gives `cell_word[11:8]`.
- R8: A cell is rendered in multicolor exactly when `multi_en`=1 and either `bitmap_mode`=1 or `cell_word[11]`=1. Every other combination renders the cell in hi-res.
- R9: In multicolor text mode, pair code 11 shows `{1'b0, cell_word[10:8]}`. Colour-RAM bit 3 never reaches the output there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_byte | input | 8 | Pattern byte for the next cell, sampled when the phase is 7 |
| cell_word | input | 12 | [11:8] colour-RAM nibble, [7:4] and [3:0] bitmap nibbles |
| bg_col | input | 4 | Background colour |
| xbg1_col | input | 4 | First extra background colour (text multicolor) |
| xbg2_col | input | 4 | Second extra background colour (text multicolor) |
| bitmap_mode | input | 1 | 1 = bitmap palette, 0 = text palette |
| multi_en | input | 1 | Multicolor enable |
| pix_col | output | 4 | Colour code of the current pixel |
| cell_phase | output | 3 | Pixel position within the cell |

## Verification
A wrong phase count or a missed load shows up as a whole cell of pixels taken from the wrong pattern bits, starting on the first pixel of the next cell. A shift by the wrong amount, or on the wrong phase, shifts every later pixel of that cell one or two positions early, so the error appears within two pixel clocks. A wrong rendering decision or palette entry changes the colour of the very pixel that uses it. For that reason every pixel of every cell is compared against a model, under random patterns, random colours and random mode bits.

// File: rtl/cell_pixel_serializer.sv
module cell_pixel_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pat_byte,
  input  logic [11:0] cell_word,
  input  logic [3:0]  bg_col,
  input  logic [3:0]  xbg1_col,
  input  logic [3:0]  xbg2_col,
  input  logic        bitmap_mode,
  input  logic        multi_en,
  output logic [3:0]  pix_col,
  output logic [2:0]  cell_phase
);

  logic [2:0] phase;
  logic [7:0] sh;
  logic       mc_cell;
  logic [3:0] mc_col;
  logic [3:0] hr_col;

  assign mc_cell = multi_en & (bitmap_mode | cell_word[11]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 3'd0;
      sh    <= 8'h00;
    end else begin
      phase <= phase + 3'd1;
      if (phase == 3'd7)
        sh <= pat_byte;
      else if (mc_cell) begin
        if (phase[0])
          sh <= {sh[5:0], 2'b00};
      end else
        sh <= {sh[6:0], 1'b0};
    end
  end

  always_comb begin
    case (sh[7:6])
      2'b00:   mc_col = bg_col;
      2'b01:   mc_col = bitmap_mode ? cell_word[7:4] : xbg1_col;
      2'b10:   mc_col = bitmap_mode ? cell_word[3:0] : xbg2_col;
      default: mc_col = bitmap_mode ? cell_word[11:8] : {1'b0, cell_word[10:8]};
    endcase
  end

  assign hr_col     = sh[7] ? cell_word[11:8] : bg_col;
  assign pix_col    = mc_cell ? mc_col : hr_col;
  assign cell_phase = phase;

endmodule

module cell_pixel_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic [7:0] pat_byte,
  input logic [7:0] sh,
  input logic       mc_cell,
  input logic [3:0] pix_col,
  input logic [3:0] bg_col
);

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd7 |=> phase == 3'd0);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd7 |=> phase == $past(phase) + 3'd1);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd7 |=> sh == $past(pat_byte));

  p_hires_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd7 && !mc_cell) |=> sh == {$past(sh[6:0]), 1'b0});

  p_mc_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd7 && mc_cell && phase[0]) |=> sh == {$past(sh[5:0]), 2'b00});

  p_mc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_cell && !phase[0]) |=> $stable(sh));

  p_zero_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sh[7:6] == 2'b00 |-> pix_col == bg_col);

endmodule

bind cell_pixel_serializer cell_pixel_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .pat_byte(pat_byte),
  .sh(sh), .mc_cell(mc_cell), .pix_col(pix_col), .bg_col(bg_col)
);

// File: tb/cell_pixel_serializer_test.sv
module cell_pixel_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pat_byte = 8'h00;
  logic [11:0] cell_word = 12'h000;
  logic [3:0]  bg_col = 4'h6;
  logic [3:0]  xbg1_col = 4'h0;
  logic [3:0]  xbg2_col = 4'h0;
  logic        bitmap_mode = 1'b0;
  logic        multi_en = 1'b0;
  logic [3:0]  pix_col;
  logic [2:0]  cell_phase;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  cell_pixel_serializer uut (
    .clk(clk), .rst_n(rst_n), .pat_byte(pat_byte), .cell_word(cell_word),
    .bg_col(bg_col), .xbg1_col(xbg1_col), .xbg2_col(xbg2_col),
    .bitmap_mode(bitmap_mode), .multi_en(multi_en),
    .pix_col(pix_col), .cell_phase(cell_phase)
  );

  function automatic logic is_mc(input logic [11:0] cw, input logic bm, input logic mc);
    return mc && (bm || cw[11]);
  endfunction

  function automatic logic [3:0] exp_pix(input logic [7:0] p, input logic [11:0] cw,
      input logic [3:0] b, input logic [3:0] x1, input logic [3:0] x2,
      input logic bm, input logic mc, input int k);
    logic [1:0] pr;
    if (is_mc(cw, bm, mc)) begin
      pr = {p[7 - 2*(k/2)], p[6 - 2*(k/2)]};
      case (pr)
        2'b00: return b;
        2'b01: return bm ? cw[7:4] : x1;
        2'b10: return bm ? cw[3:0] : x2;
        default: return bm ? cw[11:8] : {1'b0, cw[10:8]};
      endcase
    end
    return p[7 - k] ? cw[11:8] : b;
  endfunction

  function automatic string tag_of(input logic [11:0] cw, input logic bm, input logic mc);
    if (!is_mc(cw, bm, mc)) return (mc && !bm) ? "R8" : "R4";
    return bm ? "R7" : (cw[11] ? "R6/R9" : "R6");
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_cell(input logic [7:0] p, input logic [11:0] cw, input logic [3:0] b,
      input logic [3:0] x1, input logic [3:0] x2, input logic bm, input logic mc);
    pat_byte = p;
    @(posedge clk);
    #1;
    cell_word = cw; bg_col = b; xbg1_col = x1; xbg2_col = x2;
    bitmap_mode = bm; multi_en = mc;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R2", int'(cell_phase), k);
      check(k == 0 ? "R3" : (is_mc(cw, bm, mc) ? "R5" : "R4"), int'(pix_col),
            int'(exp_pix(p, cw, b, x1, x2, bm, mc, k)));
      if (tag_of(cw, bm, mc) != "R4")
        check(tag_of(cw, bm, mc), int'(pix_col), int'(exp_pix(p, cw, b, x1, x2, bm, mc, k)));
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    multi_en = 1'b1; bitmap_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(cell_phase), 0);
    check("R1", int'(pix_col), int'(bg_col));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pix_col), int'(bg_col));
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R2", int'(cell_phase), 7);

    do_cell(8'h1B, 12'hF00, 4'h1, 4'h2, 4'h3, 1'b0, 1'b1);
    do_cell(8'h1B, 12'hC9A, 4'h1, 4'h2, 4'h3, 1'b1, 1'b1);
    do_cell(8'hA5, 12'h7FF, 4'h4, 4'h2, 4'h3, 1'b0, 1'b1);
    do_cell(8'h5A, 12'hB12, 4'h4, 4'h2, 4'h3, 1'b1, 1'b0);
    do_cell(8'hFF, 12'hD00, 4'h0, 4'h5, 4'h6, 1'b0, 1'b1);
    do_cell(8'h00, 12'hFFF, 4'h9, 4'h5, 4'h6, 1'b1, 1'b1);

    for (int n = 0; n < 400; n++)
      do_cell(8'($urandom), 12'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
              1'($urandom), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule